// File: doc/BRIEF.md
# Variable-Width Control Register Bank

This block holds a chip's control registers and serves the byte-serial accesses that a control port decoder produces. A transaction opens with a start strobe that carries a 16-bit subaddress. A stream of single-byte writes or read requests follows, and an end strobe closes the transaction. The serial protocol that delivers the bytes is handled elsewhere, so it is not part of this block.

Most registers are one byte wide. The register at 0x4002 is six bytes wide and is sent most significant byte first. The bank tracks the byte position inside the current word. It advances the subaddress by one only after the last byte of a word, so a burst of any length needs a single address. Unimplemented subaddresses are holes: they take one byte per word, ignore writes and read back zero. Writes that need a running master clock are discarded while the clock-valid input is low.

Top module: `ctlreg_bank`

## Requirements
- R1: After reset every register, including the six-byte one, reads back 0x00, and `rd_valid` is low.
- R2: Within a transaction, each byte read or write at a one-byte subaddress acts on that address, and the subaddress then advances by one, so a burst walks consecutive addresses.
- R3: Subaddress 0x4002 is a six-byte word, byte 0 being bits 47:40. Written bytes are staged and reach the register together only when the sixth byte is written. The subaddress advances to 0x4003 only after the sixth byte. Reads return the committed bytes in the same order.
- R4: If a transaction ends before the sixth byte of the wide word, the staged bytes are dropped and the wide register keeps its old value.
- R5: Holes are 0x4001, 0x4003 to 0x4007, 0x402E, 0x4032 to 0x4035, and every subaddress outside 0x4000 to 0x403F. Each hole is a one-byte word: a write to it changes nothing, and a read of it returns 0x00.
- R6: While `mclk_ok` is low, writes are discarded at every subaddress except 0x4000 and 0x4002. Those two accept writes whatever the state of `mclk_ok`.
- R7: A read request returns its byte on `rd_data` one cycle later, with `rd_valid` high for exactly that cycle.
- R8: `start` takes priority over a byte operation in the same cycle, and that byte operation is dropped. When `wr_en` and `rd_en` are both high, the write is performed and the read is dropped, so `rd_valid` stays low.
- R9: `end_txn` in the same cycle as the sixth byte write of the wide word still commits that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a transaction at `sub_addr` |
| sub_addr | input | 16 | Start subaddress, taken when `start` is high |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Byte read request |
| rd_data | output | 8 | Read byte, valid with `rd_valid` |
| rd_valid | output | 1 | High one cycle after an accepted read request |
| end_txn | input | 1 | Closes the transaction and drops any partial word |
| mclk_ok | input | 1 | High while the master clock is valid |

## Verification
The end strobe and the closing sixth byte of the wide word can fall in the same cycle. The bench provokes this by raising `end_txn` together with the sixth write. It then reads the word back in a fresh transaction and expects all six new bytes. The same bench also ends a transaction after three wide bytes and expects the old word back, so the commit and drop paths are told apart. Start-versus-byte and write-versus-read collisions are driven in single cycles and judged through the next reads.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int SPAN       = 64;
    localparam int OFF_W      = $clog2(SPAN);
    localparam int WIDE_BYTES = 6;
    localparam int IDX_W      = $clog2(WIDE_BYTES);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    localparam addr_t BASE      = 16'h4000;
    localparam addr_t LIMIT     = BASE + 16'(SPAN);
    localparam addr_t WIDE_ADDR = 16'h4002;

    typedef struct packed {
        logic step;
        logic wr;
        logic rd;
    } op_t;

    function automatic logic is_hole(addr_t a);
        if (a < BASE || a >= LIMIT) return 1'b1;
        return (a == 16'h4001) || (a >= 16'h4003 && a <= 16'h4007) ||
               (a == 16'h402E) || (a >= 16'h4032 && a <= 16'h4035);
    endfunction

    function automatic logic slot_stored(int i);
        addr_t a;
        a = BASE + 16'(i);
        return !is_hole(a) && (a != WIDE_ADDR);
    endfunction

    function automatic idx_t last_index(addr_t a);
        return (a == WIDE_ADDR) ? idx_t'(WIDE_BYTES - 1) : '0;
    endfunction

    function automatic logic clock_exempt(addr_t a);
        return (a == BASE) || (a == WIDE_ADDR);
    endfunction
endpackage

// File: rtl/rb_addr_seq.sv
module rb_addr_seq
    import regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  addr_t sub_addr,
    input  logic  step,
    input  logic  end_txn,
    output addr_t cur_addr,
    output idx_t  byte_idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= BASE;
            byte_idx <= '0;
        end else if (start) begin
            cur_addr <= sub_addr;
            byte_idx <= '0;
        end else begin
            if (step) begin
                if (byte_idx == last_index(cur_addr)) begin
                    cur_addr <= cur_addr + 16'd1;
                    byte_idx <= '0;
                end else begin
                    byte_idx <= byte_idx + idx_t'(1);
                end
            end
            if (end_txn) byte_idx <= '0;
        end
    end
endmodule

// File: rtl/rb_byte_store.sv
module rb_byte_store
    import regbank_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [OFF_W-1:0]       woff,
    input  byte_t                  wdata,
    output logic [SPAN-1:0][DATA_W-1:0] q
);
    for (genvar i = 0; i < SPAN; i++) begin : g_slot
        if (slot_stored(i)) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)                          q[i] <= '0;
                else if (we && woff == OFF_W'(i)) q[i] <= wdata;
            end
        end else begin : g_none
            assign q[i] = '0;
        end
    end
endmodule

// File: rtl/rb_wide_store.sv
module rb_wide_store
    import regbank_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic stage_we,
    input  logic commit,
    input  idx_t idx,
    input  byte_t wdata,
    output logic [WIDE_BYTES-1:0][DATA_W-1:0] wide_q
);
    logic [WIDE_BYTES-2:0][DATA_W-1:0] stage_q;
    logic [WIDE_BYTES-1:0][DATA_W-1:0] merged;

    always_comb begin
        for (int i = 0; i < WIDE_BYTES - 1; i++)
            merged[WIDE_BYTES-1-i] = stage_q[i];
        merged[0] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            wide_q  <= '0;
        end else begin
            if (commit) wide_q <= merged;
            if (clr)           stage_q      <= '0;
            else if (stage_we) stage_q[idx] <= wdata;
        end
    end
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
    import regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] sub_addr,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    input  logic        end_txn,
    input  logic        mclk_ok
);
    op_t   op;
    addr_t cur_addr;
    idx_t  byte_idx;
    logic  at_wide, at_last, narrow_we, stage_we, commit;
    logic [SPAN-1:0][DATA_W-1:0]       narrow_q;
    logic [WIDE_BYTES-1:0][DATA_W-1:0] wide_q;
    logic [OFF_W-1:0] off;
    byte_t rd_byte_c;

    assign op.step = !start && (wr_en || rd_en);
    assign op.wr   = op.step && wr_en;
    assign op.rd   = op.step && !wr_en;

    rb_addr_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .sub_addr(sub_addr),
        .step(op.step), .end_txn(end_txn),
        .cur_addr(cur_addr), .byte_idx(byte_idx)
    );

    assign at_wide   = (cur_addr == WIDE_ADDR);
    assign at_last   = (byte_idx == idx_t'(WIDE_BYTES - 1));
    assign off       = OFF_W'(cur_addr - BASE);
    assign narrow_we = op.wr && !at_wide && !is_hole(cur_addr) &&
                       (mclk_ok || clock_exempt(cur_addr));
    assign stage_we  = op.wr && at_wide && !at_last;
    assign commit    = op.wr && at_wide && at_last;

    rb_byte_store u_bytes (
        .clk(clk), .rst(rst), .we(narrow_we), .woff(off),
        .wdata(wr_data), .q(narrow_q)
    );

    rb_wide_store u_wide (
        .clk(clk), .rst(rst), .clr(start || end_txn),
        .stage_we(stage_we), .commit(commit), .idx(byte_idx),
        .wdata(wr_data), .wide_q(wide_q)
    );

    always_comb begin
        if (at_wide)                rd_byte_c = wide_q[idx_t'(WIDE_BYTES - 1) - byte_idx];
        else if (is_hole(cur_addr)) rd_byte_c = '0;
        else                        rd_byte_c = narrow_q[off];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= op.rd;
            if (op.rd) rd_data <= rd_byte_c;
        end
    end
endmodule

// File: rtl/rb_checker.sv
module rb_checker
    import regbank_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        wr_en,
    input logic        rd_en,
    input logic        end_txn,
    input logic [7:0]  rd_data,
    input logic        rd_valid,
    input addr_t       cur_addr,
    input idx_t        byte_idx,
    input logic [WIDE_BYTES-1:0][DATA_W-1:0] wide_q
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!rd_valid && wide_q == '0));

    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (!start && (wr_en || rd_en) && byte_idx == last_index(cur_addr))
        |=> cur_addr == $past(cur_addr) + 16'd1);

    a_r3_index_bound: assert property (@(posedge clk) disable iff (rst)
        byte_idx <= last_index(cur_addr));

    a_r4_wide_hold: assert property (@(posedge clk) disable iff (rst)
        !(!start && wr_en && cur_addr == WIDE_ADDR &&
          byte_idx == idx_t'(WIDE_BYTES - 1)) |=> $stable(wide_q));

    a_r5_hole_zero: assert property (@(posedge clk) disable iff (rst)
        (!start && rd_en && !wr_en && is_hole(cur_addr)) |=> rd_data == 8'h00);

    a_r7_read_latency: assert property (@(posedge clk) disable iff (rst)
        (!start && rd_en && !wr_en) |=> rd_valid);

    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !(!start && rd_en && !wr_en) |=> !rd_valid);
endmodule

bind ctlreg_bank rb_checker u_chk (
    .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .rd_en(rd_en),
    .end_txn(end_txn), .rd_data(rd_data), .rd_valid(rd_valid),
    .cur_addr(cur_addr), .byte_idx(byte_idx), .wide_q(wide_q)
);

// File: tb/sim_ctlreg_bank.sv
module sim_ctlreg_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, wr_en = 1'b0, rd_en = 1'b0, end_txn = 1'b0, mclk_ok = 1'b0;
    logic [15:0] sub_addr = '0;
    logic [7:0]  wr_data = '0, rd_data;
    logic        rd_valid;
    int          n_chk = 0, n_bad = 0;

    logic [7:0]  m_mem [64];
    logic [7:0]  m_wide [6];
    logic [7:0]  m_stage [6];
    logic [15:0] m_addr;
    int          m_idx;

    always #2 clk = ~clk;

    ctlreg_bank u0 (
        .clk(clk), .rst(rst), .start(start), .sub_addr(sub_addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .end_txn(end_txn),
        .mclk_ok(mclk_ok)
    );

    function automatic bit hole(logic [15:0] a);
        if (a < 16'h4000 || a > 16'h403F) return 1;
        return a == 16'h4001 || a == 16'h402E ||
               (a >= 16'h4003 && a <= 16'h4007) || (a >= 16'h4032 && a <= 16'h4035);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic m_advance();
        if (m_addr == 16'h4002 && m_idx < 5) m_idx++;
        else begin m_addr++; m_idx = 0; end
    endtask

    task automatic open_txn(logic [15:0] a);
        @(negedge clk); start = 1; sub_addr = a;
        @(negedge clk); start = 0;
        m_addr = a; m_idx = 0;
    endtask

    task automatic close_txn();
        @(negedge clk); end_txn = 1;
        @(negedge clk); end_txn = 0;
        m_idx = 0;
    endtask

    task automatic m_write(logic [7:0] d);
        if (m_addr == 16'h4002) begin
            m_stage[m_idx] = d;
            if (m_idx == 5) for (int i = 0; i < 6; i++) m_wide[i] = m_stage[i];
        end else if (!hole(m_addr) && (mclk_ok || m_addr == 16'h4000))
            m_mem[m_addr - 16'h4000] = d;
        m_advance();
    endtask

    task automatic wbyte(logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(negedge clk); wr_en = 0;
        m_write(d);
    endtask

    task automatic rbyte(string req);
        logic [7:0] exp;
        if (m_addr == 16'h4002) exp = m_wide[m_idx];
        else if (hole(m_addr)) exp = 8'h00;
        else exp = m_mem[m_addr - 16'h4000];
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0;
        check(rd_valid === 1'b1, "R7 rd_valid", int'(rd_valid), 1);
        check(rd_data === exp, req, int'(rd_data), int'(exp));
        m_advance();
    endtask

    task automatic read_span(string req);
        open_txn(16'h4000);
        for (int k = 0; k < 69; k++) rbyte(req);
        close_txn();
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) m_mem[i] = 0;
        for (int i = 0; i < 6; i++) begin m_wide[i] = 0; m_stage[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(rd_valid === 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
        read_span("R1 reset value");

        // R2 R3 R5: full burst write with clock, then full readback
        mclk_ok = 1;
        open_txn(16'h4000);
        for (int k = 0; k < 69; k++) wbyte(8'(k * 13 + 5));
        close_txn();
        read_span("R2 R3 R5 burst readback");

        // R4: partial wide word dropped
        open_txn(16'h4002);
        for (int k = 0; k < 3; k++) wbyte(8'hE0 + 8'(k));
        close_txn();
        for (int i = 0; i < 6; i++) m_stage[i] = 0;
        open_txn(16'h4002);
        for (int k = 0; k < 6; k++) rbyte("R4 partial dropped");
        close_txn();

        // R6: no master clock
        mclk_ok = 0;
        open_txn(16'h4000);
        for (int k = 0; k < 20; k++) wbyte(8'hA0 ^ 8'(k * 3));
        close_txn();
        read_span("R6 clock gating");
        mclk_ok = 1;

        // R9: end strobe with sixth byte
        open_txn(16'h4002);
        for (int k = 0; k < 5; k++) wbyte(8'h31 + 8'(k));
        @(negedge clk); wr_en = 1; wr_data = 8'h7C; end_txn = 1;
        @(negedge clk); wr_en = 0; end_txn = 0;
        m_write(8'h7C);
        open_txn(16'h4002);
        for (int k = 0; k < 6; k++) rbyte("R9 commit with end");
        close_txn();

        // R8: start beats a same-cycle write
        @(negedge clk); start = 1; sub_addr = 16'h4010; wr_en = 1; wr_data = 8'hAA;
        @(negedge clk); start = 0; wr_en = 0;
        m_addr = 16'h4010; m_idx = 0;
        rbyte("R8 start priority");
        close_txn();

        // R8: write beats a same-cycle read
        open_txn(16'h4011);
        @(negedge clk); wr_en = 1; rd_en = 1; wr_data = 8'h55;
        @(negedge clk); wr_en = 0; rd_en = 0;
        check(rd_valid === 1'b0, "R8 read dropped", int'(rd_valid), 0);
        m_write(8'h55);
        close_txn();
        open_txn(16'h4011);
        rbyte("R8 write performed");
        close_txn();

        // R5: outside the span
        open_txn(16'h1234);
        wbyte(8'h77);
        close_txn();
        open_txn(16'h1234);
        rbyte("R5 out of range");
        rbyte("R5 out of range next");
        close_txn();

        finish_run();
    end
endmodule